// File: doc/BRIEF.md
# Slot Table Builder for a Time-Sliced Memory Arbiter

This block builds the slot table of a time-sliced memory arbiter. Each client brings a requested slot count and an active flag, and the builder also takes a budget of spare slots. On a start pulse the block captures these inputs and works through three passes. The placement pass gives every client that asked for slots a set of evenly spaced positions. The spare pass gives each active client that asked for nothing a single slot. The fill pass gives every slot still empty to an active client, taken in round-robin order.

The finished table is streamed to the arbiter's table write port as 64 consecutive writes, slot 0 first. The fill pass runs during that stream, so it costs no extra cycles. A separate combinational check tells the caller whether a further request of a given size would still fit in the table.

Top module: `slot_table_builder`

## Requirements
- R1: After reset `busy`, `done` and `wr_en` are all low.
- R2: A `start` pulse seen while the block is idle or done captures `req_cnt`, `act_mask` and `spare_cnt`. In the next cycle `busy` is high and `done` is low. While `busy` is high, `start` and any change to the inputs have no effect on the table that is written.
- R3: Clients are placed one after another in ascending index order. A client that asks for n>0 slots uses a stride of floor(64/n). Its scan starts at position 0. An occupied position moves the scan on by 1. A free position is given to the client and moves the scan on by the stride. The scan stops once the position is 64 or more. So n=3 gives 0, 21, 42 and 63.
- R4: An active client with a request of 0 gets exactly one slot, the lowest free position, but only while the spare budget is above zero. Each such grant lowers the budget by one. An inactive client with a zero request gets nothing in this pass.
- R5: A round-robin pointer starts at 0. Slots left empty after placement are filled in ascending slot order. Each one goes to the first active client found at or after the pointer, searching cyclically over the 14 clients, and the pointer then becomes that client plus one, modulo 14. A slot that is already occupied leaves the pointer unchanged.
- R6: If no client is active, an empty slot takes the pointer's own value, and the pointer then advances by one, modulo 14.
- R7: A build produces exactly 64 writes on consecutive cycles, with `wr_slot` running from 0 to 63. `wr_client` is the 4-bit client index and is always below 14.
- R8: `done` rises in the cycle after the write of slot 63. It then stays high, with `wr_en` low, until the next accepted `start`.
- R9: `adm_ok` is high exactly when the sum of all `req_cnt` entries plus `adm_cand` is at most 64.
- R10: Every build starts from an empty table, so its result does not depend on any earlier build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a build (accepted when idle or done) |
| req_cnt | input | 98 | 14 request counts of 7 bits; client c occupies bits [7c+6:7c] |
| act_mask | input | 14 | Active flag per client, bit c for client c |
| spare_cnt | input | 7 | Spare slot budget for zero-request clients |
| adm_cand | input | 7 | Slot count of a prospective new request |
| adm_ok | output | 1 | The prospective request fits in the table |
| busy | output | 1 | A build is in progress |
| wr_en | output | 1 | Table write strobe |
| wr_slot | output | 6 | Slot index being written |
| wr_client | output | 4 | Client assigned to that slot |
| done | output | 1 | The table has been fully written |

## Verification
Assertions check several properties on every cycle. The write stream must step through slots without gaps and keep client values in range, and `done` must follow the final write with the strobe quiet from then on. Placement may only write to free positions, and the spare budget may never grow during placement. Every filled slot must go to an active client, or to the pointer value when no client is active. The actual content of the table (strides, collision skipping, the order of spare grants and the path of the round-robin pointer) can only be shown by the bench, which compares every written entry against a table rebuilt independently for each configuration in its sweep. The bench also covers the admission result over the full range of candidate sizes.

// File: rtl/stb_pkg.sv
package stb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLACE,
    ST_EMIT,
    ST_FIN,
    ST_DONE
  } stb_state_e;

  // Spacing between the slots given to one client; a zero request means a
  // single grant, which a stride of the whole table produces.
  function automatic int stride_of(int n, int slots);
    if (n <= 0) return slots;
    if ((slots / n) < 1) return 1;
    return slots / n;
  endfunction

  // Cyclic successor inside [0, modulus).
  function automatic int wrap_add(int base, int add, int modulus);
    return (base + add) % modulus;
  endfunction

endpackage

// File: rtl/stb_slot_store.sv
module stb_slot_store #(
  parameter int NUM_SLOTS   = 64,
  parameter int NUM_CLIENTS = 14,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int CW = $clog2(NUM_CLIENTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [SW-1:0] raddr,
  output logic          rvalid,
  output logic [CW-1:0] rclient
);

  logic [NUM_SLOTS-1:0] occ_q;
  logic [CW-1:0]        owner_q [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (clr) begin
      occ_q <= '0;
    end else if (we) begin
      occ_q[waddr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) owner_q[waddr] <= wdata;
  end

  assign rvalid  = occ_q[raddr];
  assign rclient = owner_q[raddr];

  // R3: the placement pass only ever claims a position that is still free
  a_r3_write_to_free: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (!occ_q[waddr] && !clr));

endmodule

// File: rtl/stb_rr_pick.sv
module stb_rr_pick #(
  parameter int NUM_CLIENTS = 14,
  localparam int CW = $clog2(NUM_CLIENTS)
) (
  input  logic [NUM_CLIENTS-1:0] mask,
  input  logic [CW-1:0]          ptr,
  output logic [CW-1:0]          pick,
  output logic                   found
);
  import stb_pkg::*;

  always_comb begin
    pick  = ptr;
    found = 1'b0;
    for (int k = 0; k < NUM_CLIENTS; k++) begin
      int idx;
      idx = wrap_add(int'(ptr), k, NUM_CLIENTS);
      if (!found && mask[idx]) begin
        pick  = CW'(idx);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/stb_admit.sv
module stb_admit #(
  parameter int NUM_SLOTS   = 64,
  parameter int NUM_CLIENTS = 14,
  localparam int CNTW = $clog2(NUM_SLOTS + 1)
) (
  input  logic [NUM_CLIENTS*CNTW-1:0] req_flat,
  input  logic [CNTW-1:0]             cand,
  output logic                        ok
);

  int total;

  always_comb begin
    total = int'(cand);
    for (int c = 0; c < NUM_CLIENTS; c++) begin
      total = total + int'(req_flat[c*CNTW +: CNTW]);
    end
    ok = (total <= NUM_SLOTS);
  end

endmodule

// File: rtl/slot_table_builder.sv
module slot_table_builder #(
  parameter int NUM_SLOTS   = 64,
  parameter int NUM_CLIENTS = 14,
  localparam int SW   = $clog2(NUM_SLOTS),
  localparam int CW   = $clog2(NUM_CLIENTS),
  localparam int CNTW = $clog2(NUM_SLOTS + 1),
  localparam int POSW = CNTW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NUM_CLIENTS*CNTW-1:0] req_cnt,
  input  logic [NUM_CLIENTS-1:0]      act_mask,
  input  logic [CNTW-1:0]             spare_cnt,
  input  logic [CNTW-1:0]             adm_cand,
  output logic                        adm_ok,
  output logic                        busy,
  output logic                        wr_en,
  output logic [SW-1:0]               wr_slot,
  output logic [CW-1:0]               wr_client,
  output logic                        done
);
  import stb_pkg::*;

  localparam logic [SW-1:0]   LAST_SLOT  = SW'(NUM_SLOTS - 1);
  localparam logic [CW-1:0]   LAST_CLI   = CW'(NUM_CLIENTS - 1);
  localparam logic [POSW-1:0] SLOT_LIMIT = POSW'(NUM_SLOTS);

  stb_state_e st_q;

  logic [NUM_CLIENTS*CNTW-1:0] req_l;
  logic [NUM_CLIENTS-1:0]      act_l;
  logic [CNTW-1:0]             budget_q;
  logic [CW-1:0]               cli_q;
  logic                        scan_q;
  logic [POSW-1:0]             pos_q;
  logic [POSW-1:0]             stride_q;
  logic [SW-1:0]               eidx_q;
  logic [CW-1:0]               rr_q;

  logic                        wr_en_q;
  logic [SW-1:0]               wr_slot_q;
  logic [CW-1:0]               wr_client_q;

  // named internal events
  logic          accept_start;
  logic          place_we;
  logic          adv_client;
  logic          grant_spare;
  logic          begin_scan;
  logic          fill_evt;
  logic [CNTW-1:0] cur_req;
  logic          cur_act;
  logic          pos_out;

  logic [SW-1:0] rd_addr;
  logic          rd_valid;
  logic [CW-1:0] rd_client;
  logic [CW-1:0] rr_pick;
  logic          rr_found;

  assign cur_req = req_l[cli_q*CNTW +: CNTW];
  assign cur_act = act_l[cli_q];
  assign pos_out = (pos_q >= SLOT_LIMIT);

  always_comb begin
    accept_start = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
    begin_scan   = 1'b0;
    grant_spare  = 1'b0;
    adv_client   = 1'b0;
    place_we     = 1'b0;
    if (st_q == ST_PLACE) begin
      if (!scan_q) begin
        if (cur_req != '0) begin
          begin_scan = 1'b1;
        end else if (cur_act && (budget_q != '0)) begin
          begin_scan  = 1'b1;
          grant_spare = 1'b1;
        end else begin
          adv_client = 1'b1;
        end
      end else if (pos_out) begin
        adv_client = 1'b1;
      end else if (!rd_valid) begin
        place_we = 1'b1;
      end
    end
    fill_evt = (st_q == ST_EMIT) && !rd_valid;
    rd_addr  = (st_q == ST_EMIT) ? eidx_q : pos_q[SW-1:0];
  end

  stb_slot_store #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_CLIENTS(NUM_CLIENTS)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept_start),
    .we     (place_we),
    .waddr  (pos_q[SW-1:0]),
    .wdata  (cli_q),
    .raddr  (rd_addr),
    .rvalid (rd_valid),
    .rclient(rd_client)
  );

  stb_rr_pick #(
    .NUM_CLIENTS(NUM_CLIENTS)
  ) u_pick (
    .mask (act_l),
    .ptr  (rr_q),
    .pick (rr_pick),
    .found(rr_found)
  );

  stb_admit #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_CLIENTS(NUM_CLIENTS)
  ) u_admit (
    .req_flat(req_cnt),
    .cand    (adm_cand),
    .ok      (adm_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      req_l       <= '0;
      act_l       <= '0;
      budget_q    <= '0;
      cli_q       <= '0;
      scan_q      <= 1'b0;
      pos_q       <= '0;
      stride_q    <= '0;
      eidx_q      <= '0;
      rr_q        <= '0;
      wr_en_q     <= 1'b0;
      wr_slot_q   <= '0;
      wr_client_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      case (st_q)
        ST_IDLE, ST_DONE: begin
          if (accept_start) begin
            req_l    <= req_cnt;
            act_l    <= act_mask;
            budget_q <= spare_cnt;
            cli_q    <= '0;
            scan_q   <= 1'b0;
            st_q     <= ST_PLACE;
          end
        end
        ST_PLACE: begin
          if (begin_scan) begin
            scan_q   <= 1'b1;
            pos_q    <= '0;
            stride_q <= POSW'(stride_of(int'(cur_req), NUM_SLOTS));
            if (grant_spare) budget_q <= budget_q - 1'b1;
          end else if (adv_client) begin
            scan_q <= 1'b0;
            if (cli_q == LAST_CLI) begin
              st_q   <= ST_EMIT;
              eidx_q <= '0;
              rr_q   <= '0;
            end else begin
              cli_q <= cli_q + 1'b1;
            end
          end else if (place_we) begin
            pos_q <= pos_q + stride_q;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_EMIT: begin
          wr_en_q   <= 1'b1;
          wr_slot_q <= eidx_q;
          if (fill_evt) begin
            wr_client_q <= rr_pick;
            rr_q        <= CW'(wrap_add(int'(rr_pick), 1, NUM_CLIENTS));
          end else begin
            wr_client_q <= rd_client;
          end
          if (eidx_q == LAST_SLOT) st_q <= ST_FIN;
          else                     eidx_q <= eidx_q + 1'b1;
        end
        ST_FIN:  st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q == ST_PLACE) || (st_q == ST_EMIT) || (st_q == ST_FIN);
  assign done      = (st_q == ST_DONE);
  assign wr_en     = wr_en_q;
  assign wr_slot   = wr_slot_q;
  assign wr_client = wr_client_q;

  // R2: an accepted start makes the block busy and clears done
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R4: the spare budget only shrinks while placement runs
  a_r4_budget_nonincrease: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PLACE) |=> (budget_q <= $past(budget_q)));

  // R5: a filled slot goes to an active client whenever one exists
  a_r5_fill_active: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && rr_found) |-> act_l[rr_pick]);

  // R5: the round-robin pointer stays inside the client range
  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q <= LAST_CLI);

  // R6: with nobody active the pointer value itself is used
  a_r6_none_active: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_evt && !rr_found) |-> (rr_pick == rr_q));

  // R7: writes walk through the slots with no gap
  a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_slot != LAST_SLOT)) |=> (wr_en && (wr_slot == SW'($past(wr_slot) + 1'b1))));

  // R7: written client values stay inside the client range
  a_r7_client_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_client <= LAST_CLI));

  // R8: done follows the final write
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_slot == LAST_SLOT)) |=> done);

  // R8: no writes while done is shown
  a_r8_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

endmodule

// File: tb/sim_slot_table_builder.sv
module sim_slot_table_builder;

  localparam int PERIOD = 10;
  localparam int NS     = 64;
  localparam int NC     = 14;
  localparam int CNTW   = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NC*CNTW-1:0] req_cnt = '0;
  logic [NC-1:0]     act_mask = '0;
  logic [CNTW-1:0]   spare_cnt = '0;
  logic [CNTW-1:0]   adm_cand = '0;
  logic              adm_ok, busy, wr_en, done;
  logic [5:0]        wr_slot;
  logic [3:0]        wr_client;

  int total = 0;
  int bad   = 0;

  int req_v [NC];
  int act_v [NC];
  int spare_v;
  int want [NS];

  always #(PERIOD/2) clk = ~clk;

  slot_table_builder u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_cnt(req_cnt),
    .act_mask(act_mask), .spare_cnt(spare_cnt), .adm_cand(adm_cand),
    .adm_ok(adm_ok), .busy(busy), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_client(wr_client), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_inputs();
    for (int c = 0; c < NC; c++) begin
      req_cnt[c*CNTW +: CNTW] = CNTW'(req_v[c]);
      act_mask[c] = (act_v[c] != 0);
    end
    spare_cnt = CNTW'(spare_v);
  endtask

  // expected table rebuilt from the requirement text
  task automatic model();
    int budget, ptr;
    budget = spare_v;
    for (int s = 0; s < NS; s++) want[s] = -1;
    for (int c = 0; c < NC; c++) begin
      int step, p;
      if (req_v[c] > 0) step = NS / req_v[c];
      else if (act_v[c] != 0 && budget > 0) begin
        step = NS;
        budget--;
      end else step = 0;
      if (step > 0) begin
        p = 0;
        while (p < NS) begin
          if (want[p] < 0) begin
            want[p] = c;
            p += step;
          end else p++;
        end
      end
    end
    ptr = 0;
    for (int s = 0; s < NS; s++) begin
      if (want[s] < 0) begin
        int sel;
        sel = ptr;
        for (int t = NC - 1; t >= 0; t--) begin
          if (act_v[(ptr + t) % NC] != 0) sel = (ptr + t) % NC;
        end
        want[s] = sel;
        ptr = (sel + 1) % NC;
      end
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R10: one build, every written entry compared
  task automatic run_build(input string tag, input bit poke_mid);
    int n, last_wr, done_at, cyc, errs;
    model();
    drive_inputs();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, {tag, " R2 busy after start"}, busy, 1);
    n = 0; last_wr = -1; done_at = -1; cyc = 0; errs = 0;
    while (done_at < 0 && cyc < 3000) begin
      if (poke_mid && cyc == 20) begin
        // R2: start and input changes while busy have no effect
        req_cnt  = '1;
        act_mask = '0;
        spare_cnt = '1;
        start = 1'b1;
      end
      if (poke_mid && cyc == 21) start = 1'b0;
      if (wr_en) begin
        if (n < NS) begin
          if (int'(wr_slot) != n) begin
            errs++;
            chk(0, {tag, " R7 slot order"}, wr_slot, n);
          end
          if (int'(wr_client) != want[n]) begin
            errs++;
            chk(0, {tag, " R3/R4/R5 entry"}, wr_client, want[n]);
          end
        end
        n++;
        last_wr = cyc;
      end
      if (done) done_at = cyc;
      @(negedge clk);
      cyc++;
    end
    chk(errs == 0, {tag, " R3 R4 R5 R6 R10 table"}, errs, 0);
    chk(n == NS, {tag, " R7 write count"}, n, NS);
    chk(done_at == last_wr + 1, {tag, " R8 done timing"}, done_at, last_wr + 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done && !wr_en, {tag, " R8 done holds"}, {done, wr_en}, 2);
    end
  endtask

  task automatic clear_cfg();
    for (int c = 0; c < NC; c++) begin
      req_v[c] = 0;
      act_v[c] = 0;
    end
    spare_v = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_en, "R1 reset state", {busy, done, wr_en}, 0);

    // R6: nobody active, nothing requested
    clear_cfg();
    run_build("none_active", 0);

    // R3: one client takes the whole table
    clear_cfg();
    req_v[5] = 64; act_v[5] = 1;
    run_build("full_one", 0);

    // R3: stride 21 lands on 0,21,42,63 with a collision-skipped neighbour
    clear_cfg();
    req_v[0] = 3; req_v[1] = 3; act_v[2] = 1;
    run_build("stride21", 0);

    // R4: all active, zero requests, large budget
    clear_cfg();
    for (int c = 0; c < NC; c++) act_v[c] = 1;
    spare_v = 64;
    run_build("spare_all", 0);

    // R4: budget runs out partway; inactive zero clients skipped
    clear_cfg();
    for (int c = 0; c < NC; c++) act_v[c] = c % 3;
    req_v[4] = 8; spare_v = 3;
    run_build("spare_short", 0);

    // R2: mid-build poke is ignored
    clear_cfg();
    req_v[2] = 5; req_v[9] = 7; act_v[9] = 1; act_v[11] = 1; spare_v = 2;
    run_build("busy_ignore", 1);

    // R10 and general sweep: arithmetic configurations, back to back
    for (int k = 0; k < 40; k++) begin
      int tot;
      tot = 0;
      for (int c = 0; c < NC; c++) begin
        int v;
        v = (k * 7 + c * 13 + k * c) % 11;
        if (v > 6) v = 0;
        if (tot + v > NS) v = 0;
        req_v[c] = v;
        tot += v;
        act_v[c] = ((k * 5 + c * 3) % 4 != 0) ? 1 : 0;
      end
      spare_v = k % 6;
      run_build($sformatf("sweep%0d", k), 0);
    end

    // R9: admission over all candidate sizes for two fixed loads
    for (int p = 0; p < 2; p++) begin
      int sum;
      sum = 0;
      for (int c = 0; c < NC; c++) begin
        int v;
        v = (p == 0) ? (c % 4) : ((c == 3) ? 40 : 1);
        req_cnt[c*CNTW +: CNTW] = CNTW'(v);
        sum += v;
      end
      for (int cand = 0; cand <= NS; cand++) begin
        adm_cand = CNTW'(cand);
        #1;
        chk(adm_ok == (sum + cand <= NS), "R9 admission", adm_ok, (sum + cand <= NS));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule